// File: doc/BRIEF.md
# Packet checksum verifier

This block watches a byte stream that arrives one byte per clock and picks out framed packets. A packet starts with a two-byte sync pattern. Next comes a byte that gives the payload size, then that many payload bytes, then one checksum byte. While the payload streams past, the block adds each byte into an 8-bit sum that wraps around. When the checksum byte arrives, it compares that byte with the sum.

Two outputs let downstream logic use the stream directly:
- A payload-valid level marks the payload bytes.
- A single-cycle error pulse marks a packet whose checksum does not match.

The block stores and forwards no payload. It tracks one packet at a time.

Top module: `pkt_sum_top`

## Requirements
- R1: While reset (active high) is asserted, and on the first cycle after it, both outputs are low. Reset, including a reset in the middle of a packet, returns the block to hunting for the first sync byte.
- R2: A packet starts when 8'h33 is taken on one rising edge and 8'hCC is taken on the next one. If the byte after 8'h33 is any other value, the block returns to hunting. If that byte is 8'h33 again, it counts as a new first sync byte.
- R3: The byte taken after the sync pair is the payload length N, an unsigned value from 0 to 255. Exactly N payload bytes follow it.
- R4: When N is not zero, the payload-valid output goes high on the rising edge that takes the first payload byte. It goes low on the rising edge that takes the checksum byte. So it is high for exactly N cycles.
- R5: The sum is the 8-bit wraparound (modulo 256) total of the N payload bytes. Carries out of bit 7 are dropped.
- R6: The error output is high for exactly one cycle, the cycle after the edge that takes the checksum byte, and only when the checksum byte differs from the sum. At all other times it is low.
- R7: When N is zero, the payload-valid output stays low. The next byte is the checksum, and it is compared against a sum of zero.
- R8: Bytes equal to 8'h33 or 8'hCC in the length, payload or checksum positions are treated as data and do not restart framing.
- R9: After the checksum byte the block hunts again at once, so a sync byte taken on the very next edge starts a new packet.
- R10: The sum and the payload count are cleared when the second sync byte is taken. A packet's result therefore never depends on earlier packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. The stream is sampled on the rising edge. |
| rst_i | input | 1 | Synchronous reset, active high |
| byte_i | input | 8 | Incoming stream byte, changes on the falling edge |
| pay_valid_o | output | 1 | High for the cycles that follow the edges taking payload bytes |
| sum_err_o | output | 1 | One-cycle pulse on a checksum mismatch |

## Verification
On a packet with a bad checksum, the falling edge of payload-valid and the rising edge of the error pulse come from the same clock edge, the one that takes the checksum byte. The bench makes this happen with mismatched checksums on both non-empty and zero-length packets. A checksum byte is followed directly by a new 0x33, so a new sync hunt also begins in the cycle the error pulse is high. A reference model in the bench is stepped once per byte and gives the expected level of both outputs after every edge. The bench compares both outputs with this model on every cycle, so a pulse that comes late, lasts too long or shows up in the wrong packet is reported.

// File: rtl/pkt_sum_pkg.sv
package pkt_sum_pkg;

    // Framing phases of the receiver
    typedef enum logic [2:0] {
        PH_SEEK_HEAD = 3'd0,
        PH_SEEK_TAIL = 3'd1,
        PH_LENGTH    = 3'd2,
        PH_BODY      = 3'd3,
        PH_CHECK     = 3'd4
    } frame_ph_t;

    // Registered state of the framing controller
    typedef struct packed {
        frame_ph_t ph;
        logic      vld;
    } frame_regs_t;

endpackage

// File: rtl/pkt_frame_fsm.sv
module pkt_frame_fsm
    import pkt_sum_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] SYNC_HEAD = 8'h33,
    parameter logic [DATA_W-1:0] SYNC_TAIL = 8'hCC
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              body_last_i,
    output logic              sync_hit_o,
    output logic              len_take_o,
    output logic              body_take_o,
    output logic              chk_take_o,
    output logic              body_vld_o
);

    frame_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        sync_hit_o  = 1'b0;
        len_take_o  = 1'b0;
        body_take_o = 1'b0;
        chk_take_o  = 1'b0;
        // valid follows every edge that takes a payload byte
        regs_d.vld  = (regs_q.ph == PH_BODY);
        case (regs_q.ph)
            PH_SEEK_HEAD: begin
                if (byte_i == SYNC_HEAD) regs_d.ph = PH_SEEK_TAIL;
            end
            PH_SEEK_TAIL: begin
                if (byte_i == SYNC_TAIL) begin
                    regs_d.ph  = PH_LENGTH;
                    sync_hit_o = 1'b1;
                end else if (byte_i == SYNC_HEAD) begin
                    regs_d.ph = PH_SEEK_TAIL;
                end else begin
                    regs_d.ph = PH_SEEK_HEAD;
                end
            end
            PH_LENGTH: begin
                len_take_o = 1'b1;
                regs_d.ph  = (byte_i == '0) ? PH_CHECK : PH_BODY;
            end
            PH_BODY: begin
                body_take_o = 1'b1;
                if (body_last_i) regs_d.ph = PH_CHECK;
            end
            PH_CHECK: begin
                chk_take_o = 1'b1;
                regs_d.ph  = PH_SEEK_HEAD;
            end
            default: regs_d.ph = PH_SEEK_HEAD;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            regs_q <= '{ph: PH_SEEK_HEAD, vld: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign body_vld_o = regs_q.vld;

endmodule

// File: rtl/pkt_len_counter.sv
module pkt_len_counter #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic              dec_i,
    input  logic [DATA_W-1:0] len_i,
    output logic              last_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (clr_i) begin
            left_d = '0;
        end else if (load_i) begin
            left_d = len_i;
        end else if (dec_i && left_q != '0) begin
            left_d = left_q - ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign last_o = (left_q == ONE);

endmodule

// File: rtl/pkt_sum_acc.sv
module pkt_sum_acc #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic              cmp_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              err_o
);

    logic [DATA_W-1:0] sum_d, sum_q;
    logic              err_d, err_q;

    always_comb begin
        sum_d = sum_q;
        if (clr_i) begin
            sum_d = '0;
        end else if (add_i) begin
            sum_d = sum_q + byte_i;
        end
        err_d = cmp_i && (sum_q != byte_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sum_q <= '0;
            err_q <= 1'b0;
        end else begin
            sum_q <= sum_d;
            err_q <= err_d;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/pkt_sum_top.sv
module pkt_sum_top #(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] SYNC_HEAD = 8'h33,
    parameter logic [DATA_W-1:0] SYNC_TAIL = 8'hCC
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              pay_valid_o,
    output logic              sum_err_o
);

    logic sync_hit;
    logic len_take;
    logic body_take;
    logic chk_take;
    logic body_last;

    pkt_frame_fsm #(
        .DATA_W   (DATA_W),
        .SYNC_HEAD(SYNC_HEAD),
        .SYNC_TAIL(SYNC_TAIL)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .byte_i     (byte_i),
        .body_last_i(body_last),
        .sync_hit_o (sync_hit),
        .len_take_o (len_take),
        .body_take_o(body_take),
        .chk_take_o (chk_take),
        .body_vld_o (pay_valid_o)
    );

    pkt_len_counter #(
        .DATA_W(DATA_W)
    ) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (sync_hit),
        .load_i(len_take),
        .dec_i (body_take),
        .len_i (byte_i),
        .last_o(body_last)
    );

    pkt_sum_acc #(
        .DATA_W(DATA_W)
    ) u_acc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (sync_hit),
        .add_i (body_take),
        .cmp_i (chk_take),
        .byte_i(byte_i),
        .err_o (sum_err_o)
    );

endmodule

// File: rtl/pkt_sum_top_sva.sv
module pkt_sum_top_sva #(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] SYNC_TAIL = 8'hCC
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [DATA_W-1:0] byte_i,
    input logic              pay_valid_o,
    input logic              sum_err_o
);

    // R1: outputs are low on the cycle after reset was applied
    assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!pay_valid_o && !sum_err_o));

    // R6: the error pulse lasts exactly one cycle
    assert_err_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        sum_err_o |=> !sum_err_o);

    // R4: valid is already low while an error is reported
    assert_err_not_in_body_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        sum_err_o |-> !pay_valid_o);

    // R4: valid rises only two bytes after the second sync byte, with a nonzero length
    assert_valid_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pay_valid_o) |-> ($past(byte_i, 3) == SYNC_TAIL && $past(byte_i, 2) != '0));

    // R7: an error follows a payload, or a zero length right after the sync pair
    assert_err_origin_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        sum_err_o |-> ($past(pay_valid_o) ||
                       ($past(byte_i, 2) == '0 && $past(byte_i, 3) == SYNC_TAIL)));

endmodule

bind pkt_sum_top pkt_sum_top_sva #(
    .DATA_W   (DATA_W),
    .SYNC_TAIL(SYNC_TAIL)
) u_sva (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .byte_i     (byte_i),
    .pay_valid_o(pay_valid_o),
    .sum_err_o  (sum_err_o)
);

// File: tb/pkt_sum_top_bench.sv
`timescale 1ns/1ps
module pkt_sum_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic       pv;
    logic       err;

    int checks = 0;
    int errors = 0;

    // reference model state
    int         m_phase;  // 0 seek head, 1 seek tail, 2 length, 3 body, 4 check
    int         m_left;
    int         m_sum;
    logic       exp_pv;
    logic       exp_err;

    always #2 clk = ~clk;

    pkt_sum_top u_pkt_sum_top (
        .clk_i      (clk),
        .rst_i      (rst),
        .byte_i     (din),
        .pay_valid_o(pv),
        .sum_err_o  (err)
    );

    task automatic check(input string tag);
        checks++;
        if (pv !== exp_pv || err !== exp_err) begin
            errors++;
            $display("FAIL %s: valid/err actual %b/%b expected %b/%b",
                     tag, pv, err, exp_pv, exp_err);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_left = 0; m_sum = 0; exp_pv = 1'b0; exp_err = 1'b0;
    endtask

    task automatic model_step(input logic [7:0] b);
        exp_pv  = (m_phase == 3);
        exp_err = (m_phase == 4) && (m_sum != int'(b));
        if (m_phase == 0) begin
            if (b == 8'h33) m_phase = 1;
        end else if (m_phase == 1) begin
            if (b == 8'hCC) begin m_phase = 2; m_sum = 0; end
            else if (b != 8'h33) m_phase = 0;
        end else if (m_phase == 2) begin
            m_left  = int'(b);
            m_phase = (b == 0) ? 4 : 3;
        end else if (m_phase == 3) begin
            m_sum  = (m_sum + int'(b)) % 256;
            m_left = m_left - 1;
            if (m_left == 0) m_phase = 4;
        end else begin
            m_phase = 0;
        end
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        @(negedge clk);
        din = b;
        model_step(b);
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic send_pkt(input logic [7:0] pl[$], input logic [7:0] delta, input string tag);
        int s = 0;
        send(8'h33, tag);
        send(8'hCC, tag);
        send(8'(pl.size()), tag);
        foreach (pl[i]) begin
            send(pl[i], tag);
            s = s + int'(pl[i]);
        end
        send(8'(s % 256) + delta, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        repeat (2) @(posedge clk);
        #1;
        check(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        rst = 1'b1;
        din = 8'h00;
        model_reset();
        do_reset("R1 reset state");

        // R2 R3 R4 R5: plain good packet
        send(8'h00, "R2 idle");
        send_pkt('{8'h01, 8'h02, 8'h03}, 8'h00, "R4 good packet");
        // R6: checksum mismatch
        send_pkt('{8'h10, 8'h20}, 8'h01, "R6 bad checksum");
        // R5: wraparound sum
        send_pkt('{8'hFF, 8'h80, 8'h90}, 8'h00, "R5 wrap good");
        send_pkt('{8'hFF, 8'hFF}, 8'h02, "R5 wrap bad");
        // R7: zero-length packets
        send_pkt('{}, 8'h00, "R7 empty good");
        send_pkt('{}, 8'h05, "R7 empty bad");
        // R2: broken and repeated sync
        send(8'h33, "R2 false head");
        send(8'h12, "R2 false tail");
        send(8'h33, "R2 double head");
        send_pkt('{8'h07}, 8'h00, "R2 after double head");
        send(8'hCC, "R2 lone tail");
        send_pkt('{8'h04, 8'h05}, 8'h03, "R2 after lone tail");
        // R8: sync-valued data inside the packet, long length equal to 0x33
        q = {};
        for (int i = 0; i < 51; i++) q.push_back((i % 3 == 0) ? 8'h33 : ((i % 3 == 1) ? 8'hCC : 8'(i)));
        send_pkt(q, 8'h00, "R8 sync data good");
        send_pkt('{8'hCC, 8'h33}, 8'h00, "R8 checksum 0xFF");
        send_pkt('{8'h33, 8'h33, 8'h33}, 8'h01, "R8 sync data bad");
        // R3: full length 255
        q = {};
        for (int i = 0; i < 255; i++) q.push_back(8'(i * 7));
        send_pkt(q, 8'h00, "R3 max length");
        // R9 R10: back-to-back packets, errors overlapping the next hunt
        send_pkt('{8'hAA, 8'h55}, 8'h09, "R9 b2b bad");
        send_pkt('{8'h01}, 8'h00, "R10 b2b good");
        send_pkt('{}, 8'h11, "R9 b2b empty bad");
        send_pkt('{8'h80, 8'h80}, 8'h00, "R10 b2b wrap");
        // R1: reset in the middle of a packet
        send(8'h33, "R1 pre");
        send(8'hCC, "R1 pre");
        send(8'h05, "R1 pre");
        send(8'h01, "R1 pre");
        do_reset("R1 mid-packet reset");
        send(8'h02, "R1 after reset ignored");
        send_pkt('{8'h02, 8'h03}, 8'h00, "R1 after reset good");
        send(8'h00, "R9 trailing idle");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule